// File: doc/BRIEF.md
# Sequential Dual-Bank Exact-Match CAM

This block is a binary content-addressable table for exact-match lookups. It keeps its entries in two small RAM banks and finds a key by scanning the table over several cycles. Each entry holds a valid flag, a key and an associated value. Entries with an even index go to one bank and entries with an odd index go to the other. The two banks are read at the same bank address, so every scan cycle compares two entries.

A host fills the table through a write port that carries an index, a key, a value and a valid bit. It starts a lookup by raising a request while the engine reports ready. After the scan, the engine raises a one-cycle done pulse. With that pulse it presents a hit flag, the index of the lowest matching entry and that entry's stored value. Key width, value width and depth are parameters. The depth must be a power of two and at least 4.

Top module: `cam_seq_dual`

## Requirements
- R1: After reset `srch_ready` is high, `rsp_done` is low, and every entry is invalid, so a search misses.
- R2: A write with `wr_en` high stores key, value and valid at entry `wr_idx`. Bit 0 of `wr_idx` selects the bank (0 even, 1 odd) and the upper bits give the bank address. A later search returns that entry at that index.
- R3: An entry hits only when its valid flag is 1 and its stored key equals `srch_key` on every bit. A key that differs in one bit misses.
- R4: When several entries match, the response reports the lowest matching index and that entry's value. This holds both within one even/odd pair and across pairs.
- R5: `rsp_done` is high in the cycle after clock edge DEPTH/2+1, counting the edge that accepts the request as edge 0.
- R6: A request is accepted only when `srch_ready` is high. `srch_ready` is low while a scan is in progress. A request raised while it is low produces no response.
- R7: On a miss, `rsp_hit` is 0 and both `rsp_idx` and `rsp_val` are 0.
- R8: `rsp_done` is a single-cycle pulse for each accepted request.
- R9: Writing an entry with `wr_valid` 0 removes it from matching, and the next higher matching entry is then reported.
- R10: Entry 0 and entry DEPTH-1, the first and last slots of the scan, can both be found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | $clog2(DEPTH) | Entry index to write |
| wr_key | input | KEY_W | Key to store |
| wr_val | input | VAL_W | Value to store |
| wr_valid | input | 1 | Valid flag to store |
| srch_req | input | 1 | Search request |
| srch_key | input | KEY_W | Key to look up |
| srch_ready | output | 1 | Engine idle; a request is accepted this cycle |
| rsp_done | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | A valid matching entry was found |
| rsp_idx | output | $clog2(DEPTH) | Lowest matching index, 0 on miss |
| rsp_val | output | VAL_W | Value of that entry, 0 on miss |

## Verification
Two cases are hardest to reach from the ports. The first is a set of duplicate keys whose positions test the priority rule. The bench places duplicates inside one even/odd pair (indexes 6 and 7). It also places them across a pair boundary, with the odd one first (indexes 9 and 10). It removes the lower of a duplicate pair and searches again. The second case is a request raised during a scan. The bench holds `srch_req` high for several cycles mid-scan with a different key. Its scoreboard then flags any response that has no queued expectation.

// File: rtl/cam_dual_pkg.sv
package cam_dual_pkg;

  // Edges from request acceptance to the edge that raises the result pulse.
  function automatic int unsigned scan_latency(input int unsigned depth);
    return depth / 2 + 1;
  endfunction

  // Inside one compared pair the even lane wins; odd is chosen only if even missed.
  function automatic logic pick_odd(input logic hit_even);
    return !hit_even;
  endfunction

  // Bank address of the final pair in a scan.
  function automatic int unsigned last_pair(input int unsigned depth);
    return depth / 2 - 1;
  endfunction

endpackage

// File: rtl/cam_bank.sv
module cam_bank #(
  parameter int unsigned KEY_W = 16,
  parameter int unsigned VAL_W = 8,
  parameter int unsigned BD    = 32,
  parameter int unsigned BA_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BA_W-1:0]  wr_addr,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val,
  input  logic             rd_en,
  input  logic [BA_W-1:0]  rd_addr,
  output logic             rd_valid,
  output logic [KEY_W-1:0] rd_key,
  output logic [VAL_W-1:0] rd_val
);
  logic             mem_valid [BD];
  logic [KEY_W-1:0] mem_key   [BD];
  logic [VAL_W-1:0] mem_val   [BD];

  // Valid flags are cleared by reset; keys and values need no reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BD; i++) mem_valid[i] <= 1'b0;
    end else if (wr_en) begin
      mem_valid[wr_addr] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_key[wr_addr] <= wr_key;
      mem_val[wr_addr] <= wr_val;
    end
  end

  // Read-only search port with a registered output.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_key   <= '0;
      rd_val   <= '0;
    end else if (rd_en) begin
      rd_valid <= mem_valid[rd_addr];
      rd_key   <= mem_key[rd_addr];
      rd_val   <= mem_val[rd_addr];
    end
  end

endmodule

// File: rtl/cam_lane_match.sv
module cam_lane_match #(
  parameter int unsigned KEY_W = 16
) (
  input  logic             ent_valid,
  input  logic [KEY_W-1:0] ent_key,
  input  logic [KEY_W-1:0] look_key,
  output logic             lane_hit
);
  logic [KEY_W-1:0] bit_eq;

  assign bit_eq   = ~(ent_key ^ look_key);
  assign lane_hit = ent_valid && (&bit_eq);

endmodule

// File: rtl/cam_scan_ctrl.sv
module cam_scan_ctrl
  import cam_dual_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned BA_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srch_req,
  output logic            srch_ready,
  output logic            accept,
  output logic            rd_en,
  output logic [BA_W-1:0] rd_addr,
  output logic            cmp_vld,
  output logic [BA_W-1:0] cmp_addr,
  output logic            cmp_last
);
  localparam int unsigned LAST = last_pair(DEPTH);

  logic            issuing;
  logic [BA_W-1:0] addr_q;
  logic            at_last;

  assign at_last    = (addr_q == BA_W'(LAST));
  assign srch_ready = !issuing && !cmp_vld;
  assign accept     = srch_req && srch_ready;
  assign rd_en      = issuing;
  assign rd_addr    = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuing  <= 1'b0;
      addr_q   <= '0;
      cmp_vld  <= 1'b0;
      cmp_addr <= '0;
      cmp_last <= 1'b0;
    end else begin
      cmp_vld  <= issuing;
      cmp_addr <= addr_q;
      cmp_last <= issuing && at_last;
      if (accept) begin
        issuing <= 1'b1;
        addr_q  <= '0;
      end else if (issuing) begin
        addr_q <= addr_q + 1'b1;
        if (at_last) issuing <= 1'b0;
      end
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    issuing |-> (addr_q <= BA_W'(LAST)));  // R5
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issuing) |-> $past(srch_req));  // R6
  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_last |-> cmp_vld);  // R5

endmodule

// File: rtl/cam_result_fold.sv
module cam_result_fold
  import cam_dual_pkg::*;
#(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned BA_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             cmp_vld,
  input  logic             cmp_last,
  input  logic [BA_W-1:0]  cmp_addr,
  input  logic             hit_even,
  input  logic             hit_odd,
  input  logic [VAL_W-1:0] val_even,
  input  logic [VAL_W-1:0] val_odd,
  output logic             rsp_done,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [VAL_W-1:0] rsp_val
);
  logic             found;
  logic [IDX_W-1:0] f_idx;
  logic [VAL_W-1:0] f_val;
  logic             pair_hit;
  logic [IDX_W-1:0] pair_idx;
  logic [VAL_W-1:0] pair_val;
  logic             take;
  logic             nx_found;
  logic [IDX_W-1:0] nx_idx;
  logic [VAL_W-1:0] nx_val;
  logic             finish;

  assign pair_hit = hit_even || hit_odd;
  assign pair_idx = {cmp_addr, pick_odd(hit_even)};
  assign pair_val = hit_even ? val_even : val_odd;
  assign take     = cmp_vld && pair_hit && !found;
  assign nx_found = found || take;
  assign nx_idx   = take ? pair_idx : f_idx;
  assign nx_val   = take ? pair_val : f_val;
  assign finish   = cmp_vld && cmp_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found <= 1'b0;
      f_idx <= '0;
      f_val <= '0;
    end else if (accept) begin
      found <= 1'b0;
      f_idx <= '0;
      f_val <= '0;
    end else if (cmp_vld) begin
      found <= nx_found;
      f_idx <= nx_idx;
      f_val <= nx_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done <= 1'b0;
      rsp_hit  <= 1'b0;
      rsp_idx  <= '0;
      rsp_val  <= '0;
    end else begin
      rsp_done <= finish;
      if (finish) begin
        rsp_hit <= nx_found;
        rsp_idx <= nx_found ? nx_idx : '0;
        rsp_val <= nx_found ? nx_val : '0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);  // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_hit) |-> (rsp_idx == '0 && rsp_val == '0));  // R7
  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld && found) |=> $stable(f_idx));  // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(cmp_vld && cmp_last));  // R5

endmodule

// File: rtl/cam_seq_dual.sv
module cam_seq_dual
  import cam_dual_pkg::*;
#(
  parameter int unsigned KEY_W = 16,
  parameter int unsigned VAL_W = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val,
  input  logic             wr_valid,
  input  logic             srch_req,
  input  logic [KEY_W-1:0] srch_key,
  output logic             srch_ready,
  output logic             rsp_done,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [VAL_W-1:0] rsp_val
);
  localparam int unsigned BD   = DEPTH / 2;
  localparam int unsigned BA_W = IDX_W - 1;

  logic             accept;
  logic             rd_en;
  logic [BA_W-1:0]  rd_addr;
  logic             cmp_vld;
  logic [BA_W-1:0]  cmp_addr;
  logic             cmp_last;
  logic [KEY_W-1:0] look_key;

  logic             lane_valid [2];
  logic [KEY_W-1:0] lane_key   [2];
  logic [VAL_W-1:0] lane_val   [2];
  logic             lane_hit   [2];

  always_ff @(posedge clk) begin
    if (!rst_n)      look_key <= '0;
    else if (accept) look_key <= srch_key;
  end

  cam_scan_ctrl #(.DEPTH(DEPTH), .BA_W(BA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .srch_req(srch_req), .srch_ready(srch_ready),
    .accept(accept), .rd_en(rd_en), .rd_addr(rd_addr),
    .cmp_vld(cmp_vld), .cmp_addr(cmp_addr), .cmp_last(cmp_last)
  );

  // Lane 0 holds even indexes, lane 1 holds odd indexes.
  for (genvar g = 0; g < 2; g++) begin : g_lane
    cam_bank #(.KEY_W(KEY_W), .VAL_W(VAL_W), .BD(BD), .BA_W(BA_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && (wr_idx[0] == 1'(g))), .wr_addr(wr_idx[IDX_W-1:1]),
      .wr_valid(wr_valid), .wr_key(wr_key), .wr_val(wr_val),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_valid(lane_valid[g]), .rd_key(lane_key[g]), .rd_val(lane_val[g])
    );
    cam_lane_match #(.KEY_W(KEY_W)) u_match (
      .ent_valid(lane_valid[g]), .ent_key(lane_key[g]),
      .look_key(look_key), .lane_hit(lane_hit[g])
    );
  end

  cam_result_fold #(.VAL_W(VAL_W), .IDX_W(IDX_W), .BA_W(BA_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .cmp_vld(cmp_vld), .cmp_last(cmp_last), .cmp_addr(cmp_addr),
    .hit_even(lane_hit[0]), .hit_odd(lane_hit[1]),
    .val_even(lane_val[0]), .val_odd(lane_val[1]),
    .rsp_done(rsp_done), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_val(rsp_val)
  );

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld |-> !srch_ready);  // R6
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> srch_ready);  // R6

endmodule

// File: tb/cam_seq_dual_tb_top.sv
`timescale 1ns/1ps
module cam_seq_dual_tb_top;
  localparam int KW = 16;
  localparam int VW = 8;
  localparam int D  = 16;
  localparam int IW = 4;
  localparam int LAT = D / 2 + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [KW-1:0] wr_key = '0;
  logic [VW-1:0] wr_val = '0;
  logic          wr_valid = 1'b0;
  logic          srch_req = 1'b0;
  logic [KW-1:0] srch_key = '0;
  logic          srch_ready, rsp_done, rsp_hit;
  logic [IW-1:0] rsp_idx;
  logic [VW-1:0] rsp_val;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;
  logic prev_done = 1'b0;

  typedef struct {
    logic          hit;
    int            idx;
    logic [VW-1:0] val;
    int            c0;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic          m_valid [D];
  logic [KW-1:0] m_key   [D];
  logic [VW-1:0] m_val   [D];

  cam_seq_dual #(.KEY_W(KW), .VAL_W(VW), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
    .wr_val(wr_val), .wr_valid(wr_valid), .srch_req(srch_req), .srch_key(srch_key),
    .srch_ready(srch_ready), .rsp_done(rsp_done), .rsp_hit(rsp_hit),
    .rsp_idx(rsp_idx), .rsp_val(rsp_val)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each result pulse.
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (prev_done && rsp_done) check(0, "R8 done longer than one cycle", 1, 0);
      if (rsp_done) begin
        if (sb.size() == 0) begin
          check(0, "R6 response without accepted request", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc - e.c0 == LAT, {e.tag, " R5 latency"}, cyc - e.c0, LAT);
          check(rsp_hit == e.hit, {e.tag, " hit"}, int'(rsp_hit), int'(e.hit));
          check(int'(rsp_idx) == e.idx, {e.tag, " index"}, int'(rsp_idx), e.idx);
          check(rsp_val == e.val, {e.tag, " value"}, int'(rsp_val), int'(e.val));
        end
      end
      prev_done = rsp_done;
    end
  end

  task automatic write_ent(input int idx, input logic [KW-1:0] k,
                           input logic [VW-1:0] v, input logic vld);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_key = k; wr_val = v; wr_valid = vld;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    m_valid[idx] = vld; m_key[idx] = k; m_val[idx] = v;
  endtask

  // Driver: computes the expectation from the table model and queues it.
  task automatic search(input logic [KW-1:0] k, input string tag);
    exp_t e;
    e.hit = 1'b0; e.idx = 0; e.val = '0; e.tag = tag;
    for (int i = D - 1; i >= 0; i--) begin
      if (m_valid[i] && m_key[i] == k) begin
        e.hit = 1'b1; e.idx = i; e.val = m_val[i];
      end
    end
    @(negedge clk);
    while (!srch_ready) @(negedge clk);
    srch_req = 1'b1; srch_key = k;
    @(posedge clk);
    @(negedge clk);
    srch_req = 1'b0;
    e.c0 = cyc;
    sb.push_back(e);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (sb.size() != 0 || !srch_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(10 * 150000);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin
      m_valid[i] = 1'b0; m_key[i] = '0; m_val[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(srch_ready == 1'b1, "R1 ready after reset", int'(srch_ready), 1);
    check(rsp_done == 1'b0, "R1 done low after reset", int'(rsp_done), 0);
    search(16'h1234, "R1 R7 empty table miss");
    wait_idle();

    write_ent(0, 16'h00AA, 8'h11, 1'b1);
    write_ent(D - 1, 16'h0BBB, 8'h22, 1'b1);
    write_ent(5, 16'h0CCC, 8'h33, 1'b1);
    write_ent(8, 16'h0CCC, 8'h44, 1'b1);
    write_ent(6, 16'h0DDD, 8'h55, 1'b1);
    write_ent(7, 16'h0DDD, 8'h66, 1'b1);
    write_ent(9, 16'h0EEE, 8'h77, 1'b1);
    write_ent(10, 16'h0EEE, 8'h88, 1'b1);
    write_ent(3, 16'h0F0F, 8'h99, 1'b1);
    write_ent(12, 16'h0777, 8'hAB, 1'b0);

    search(16'h00AA, "R10 R2 entry zero");
    search(16'h0BBB, "R10 R2 last entry");
    search(16'h0CCC, "R4 lowest across pairs");
    search(16'h0DDD, "R4 even wins in pair");
    search(16'h0EEE, "R4 odd wins across pair");
    search(16'h0F0F, "R3 exact match");
    search(16'h0F0E, "R3 one bit differs");
    search(16'h8F0F, "R3 top bit differs");
    search(16'h0777, "R3 invalid entry miss");
    wait_idle();

    write_ent(5, 16'h0CCC, 8'h33, 1'b0);
    search(16'h0CCC, "R9 removed entry skipped");
    wait_idle();

    // Requests raised during a scan must be ignored.
    search(16'h00AA, "R6 scan with busy requests");
    @(negedge clk);
    check(srch_ready == 1'b0, "R6 ready low during scan", int'(srch_ready), 0);
    srch_req = 1'b1; srch_key = 16'h0BBB;
    repeat (3) @(negedge clk);
    srch_req = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
    wait_idle();

    for (int n = 0; n < 24; n++) begin
      if (n % 4 == 0) begin
        wait_idle();
        write_ent(int'($urandom % D), {12'hA50, 4'($urandom % 8)},
                  8'($urandom), 1'($urandom % 4 != 0));
      end
      search({12'hA50, 4'($urandom % 8)}, "R2 R4 mixed traffic");
    end
    wait_idle();

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule